// File: doc/BRIEF.md
# Zero Forcing Graph Propagation Engine

This block colours the vertices of a small undirected graph black or white and repeatedly applies one propagation rule. A black vertex whose neighbourhood holds exactly one white vertex turns that neighbour black. Black is logic 1 and white is logic 0. Software or a neighbouring block writes the adjacency one row per cycle. A start pulse then captures an initial colouring and a vertex-enable mask. After that the engine performs one propagation round per clock until a round leaves the colouring unchanged.

Small gadgets built through the adjacency act as monotone logic gates. A triangle with two input vertices gives AND. A four-vertex gadget with one vertex precoloured black gives OR. Larger circuits come from joining such gadgets into a single graph. While the rounds run, the engine shows the current colouring and a step count. At the end it reports whether every enabled vertex became black, which means the initial set was a forcing set. It also reports whether any propagation ran backwards, meaning it was driven by a vertex that had already been black before the previous round.

Top module: `zf_engine`

## Requirements
- R1: In each round, every black vertex whose set of white neighbours has exactly one member turns that member black. All forcings in a round are computed from the colouring held at the start of that round and take effect together on the next clock.
- R2: A black vertex never becomes white during a run. Between rounds the colouring only gains bits.
- R3: `done` rises in the cycle after the first round that changes nothing. From then until the next start, the colouring stays unchanged.
- R4: `round_cnt` is 1 right after start and increases by one for each round that changes the colouring. A round that changes nothing does not increase it.
- R5: For a triangle on vertices 0, 1 and 2, with inputs 0 and 1 and output 2, vertex 2 ends black exactly when both inputs start black. When it does, `round_cnt` is 2 at done.
- R6: For edges 0-2, 0-3, 1-2 and 1-3, with vertex 2 precoloured black, inputs 0 and 1 and output 3, any black input makes vertex 3 black at step 2. Whenever vertex 3 ends black, all four vertices end black.
- R7: `back_force` is set, and stays set until the next start, when a round blackens a vertex whose only forcers were black before the previous round. The vertices that count as fresh in round 1 are the initial black set.
- R8: Diagonal bits of the adjacency are ignored. `sym_err` is high while any stored bit (i,j) with i different from j differs from bit (j,i).
- R9: A vertex whose `vtx_en` bit was 0 at start stays white and has no edges. `all_black` is high exactly when `done` is high and every enabled vertex is black.
- R10: Adjacency writes are ignored while a run is in progress.
- R11: `start` loads `init_color` ANDed with `vtx_en` as the colouring, and it restarts the engine even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adj_we | input | 1 | Write one adjacency row |
| adj_idx | input | 4 | Row (vertex) being written |
| adj_row | input | 16 | Neighbour bits of that vertex |
| vtx_en | input | 16 | Enabled vertices, captured at start |
| start | input | 1 | Capture initial colouring and begin rounds |
| init_color | input | 16 | Initial colouring, 1 = black |
| color | output | 16 | Current colouring |
| running | output | 1 | Rounds in progress |
| done | output | 1 | Final colouring reached |
| round_cnt | output | 5 | Step count, initial colouring = 1 |
| all_black | output | 1 | Done and every enabled vertex black |
| back_force | output | 1 | A stale vertex forced during this run |
| sym_err | output | 1 | Stored adjacency is not symmetric |

## Verification
The embedded properties check several rules on every cycle of every run. The colouring never loses a black bit during a run. It stays frozen once done is reached. Disabled vertices are never black. The step count either advances by one or the engine stops. The back-forcing flag holds once it is set. Only the bench scenarios can show that the forcing rule picks exactly the right vertices. Those scenarios are a full sweep of the AND and OR gadget inputs, a long path, a deliberate backward forcing, symmetry faults and randomly generated graphs compared round by round against an arithmetic model. The same scenarios also cover the effect of ignored writes.

// File: rtl/zf_pkg.sv
package zf_pkg;
    typedef enum logic [1:0] {
        ZF_IDLE = 2'd0,
        ZF_RUN  = 2'd1,
        ZF_DONE = 2'd2
    } zf_phase_e;
endpackage

// File: rtl/zf_adj_store.sv
module zf_adj_store #(
    parameter int NV    = 16,
    parameter int IDX_W = $clog2(NV)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [NV-1:0]        wr_row,
    input  logic [NV-1:0]        vtx_mask,
    output logic [NV*NV-1:0]     adj_eff,
    output logic                 asym
);
    logic [NV-1:0] adj_d [NV];
    logic [NV-1:0] adj_q [NV];

    always_comb begin
        for (int i = 0; i < NV; i++) begin
            adj_d[i] = adj_q[i];
            if (wr_en && int'(wr_idx) == i) adj_d[i] = wr_row;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NV; i++) adj_q[i] <= '0;
        end else begin
            for (int i = 0; i < NV; i++) adj_q[i] <= adj_d[i];
        end
    end

    // Effective edges: no self loops, both endpoints enabled.
    for (genvar gi = 0; gi < NV; gi++) begin : g_row
        for (genvar gj = 0; gj < NV; gj++) begin : g_col
            if (gi == gj) begin : g_diag
                assign adj_eff[gi*NV+gj] = 1'b0;
            end else begin : g_off
                assign adj_eff[gi*NV+gj] = adj_q[gi][gj] & vtx_mask[gi] & vtx_mask[gj];
            end
        end
    end

    always_comb begin
        asym = 1'b0;
        for (int i = 0; i < NV; i++)
            for (int j = i + 1; j < NV; j++)
                asym = asym | (adj_q[i][j] ^ adj_q[j][i]);
    end
endmodule

// File: rtl/zf_round.sv
module zf_round #(
    parameter int NV = 16
) (
    input  logic [NV*NV-1:0] adj_eff,
    input  logic [NV-1:0]    color,
    input  logic [NV-1:0]    fresh_set,
    output logic [NV-1:0]    color_nxt,
    output logic             back_hit
);
    localparam int CW = $clog2(NV + 1);

    logic [NV-1:0] push [NV];

    for (genvar gi = 0; gi < NV; gi++) begin : g_vtx
        logic [NV-1:0] white_nb;
        logic [CW-1:0] white_cnt;
        logic          fires;
        assign white_nb  = adj_eff[gi*NV +: NV] & ~color;
        assign white_cnt = CW'($countones(white_nb));
        assign fires     = color[gi] && (white_cnt == CW'(1));
        assign push[gi]  = fires ? white_nb : '0;
    end

    logic [NV-1:0] from_fresh;
    logic [NV-1:0] from_stale;

    always_comb begin
        from_fresh = '0;
        from_stale = '0;
        for (int i = 0; i < NV; i++) begin
            if (fresh_set[i]) from_fresh = from_fresh | push[i];
            else              from_stale = from_stale | push[i];
        end
        color_nxt = color | from_fresh | from_stale;
        back_hit  = |(from_stale & ~from_fresh);
    end
endmodule

// File: rtl/zf_engine.sv
module zf_engine #(
    parameter int NV    = 16,
    parameter int CNT_W = $clog2(NV + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     adj_we,
    input  logic [$clog2(NV)-1:0]    adj_idx,
    input  logic [NV-1:0]            adj_row,
    input  logic [NV-1:0]            vtx_en,
    input  logic                     start,
    input  logic [NV-1:0]            init_color,
    output logic [NV-1:0]            color,
    output logic                     running,
    output logic                     done,
    output logic [CNT_W-1:0]         round_cnt,
    output logic                     all_black,
    output logic                     back_force,
    output logic                     sym_err
);
    import zf_pkg::*;

    localparam int IDX_W = $clog2(NV);

    typedef struct packed {
        zf_phase_e         phase;
        logic [NV-1:0]     color;
        logic [NV-1:0]     fresh;
        logic [NV-1:0]     en;
        logic [CNT_W-1:0]  cnt;
        logic              back;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic [NV*NV-1:0] adj_eff;
    logic [NV-1:0]    color_nxt;
    logic             back_hit;
    logic             wr_ok;

    assign wr_ok = adj_we && (st_q.phase != ZF_RUN);

    zf_adj_store #(.NV(NV), .IDX_W(IDX_W)) u_adj (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_ok),
        .wr_idx   (adj_idx),
        .wr_row   (adj_row),
        .vtx_mask (st_q.en),
        .adj_eff  (adj_eff),
        .asym     (sym_err)
    );

    zf_round #(.NV(NV)) u_round (
        .adj_eff   (adj_eff),
        .color     (st_q.color),
        .fresh_set (st_q.fresh),
        .color_nxt (color_nxt),
        .back_hit  (back_hit)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.phase = ZF_RUN;
            st_d.color = init_color & vtx_en;
            st_d.fresh = init_color & vtx_en;
            st_d.en    = vtx_en;
            st_d.cnt   = CNT_W'(1);
            st_d.back  = 1'b0;
        end else if (st_q.phase == ZF_RUN) begin
            if (color_nxt == st_q.color) begin
                st_d.phase = ZF_DONE;
                st_d.fresh = '0;
            end else begin
                st_d.color = color_nxt;
                st_d.fresh = color_nxt & ~st_q.color;
                st_d.cnt   = st_q.cnt + CNT_W'(1);
                st_d.back  = st_q.back | back_hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign color      = st_q.color;
    assign running    = (st_q.phase == ZF_RUN);
    assign done       = (st_q.phase == ZF_DONE);
    assign round_cnt  = st_q.cnt;
    assign back_force = st_q.back;
    assign all_black  = done && ((st_q.color & st_q.en) == st_q.en);

    AST_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start) |=> ((color & $past(color)) == $past(color))); // R2

    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(color))); // R3

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start) |=> (done || round_cnt == $past(round_cnt) + CNT_W'(1))); // R4

    AST_BACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (back_force && !start) |=> back_force); // R7

    AST_DISABLED_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
        (running || done) |-> ((color & ~st_q.en) == '0)); // R9
endmodule

// File: tb/zf_engine_bench.sv
module zf_engine_bench;
    localparam int NV = 16;
    localparam int CNT_W = $clog2(NV + 2);
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adj_we = 1'b0;
    logic [3:0] adj_idx = '0;
    logic [NV-1:0] adj_row = '0;
    logic [NV-1:0] vtx_en = '0;
    logic start = 1'b0;
    logic [NV-1:0] init_color = '0;
    logic [NV-1:0] color;
    logic running, done, all_black, back_force, sym_err;
    logic [CNT_W-1:0] round_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [NV-1:0] gadj [NV];

    zf_engine u_zf_engine (
        .clk(clk), .rst_n(rst_n), .adj_we(adj_we), .adj_idx(adj_idx),
        .adj_row(adj_row), .vtx_en(vtx_en), .start(start),
        .init_color(init_color), .color(color), .running(running),
        .done(done), .round_cnt(round_cnt), .all_black(all_black),
        .back_force(back_force), .sym_err(sym_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit edge_on(input int i, input int j, input logic [NV-1:0] en);
        return (i != j) && gadj[i][j] && en[i] && en[j];
    endfunction

    // One round of the rule computed from the requirements.
    task automatic model_round(input logic [NV-1:0] c, input logic [NV-1:0] fr,
                               input logic [NV-1:0] en,
                               output logic [NV-1:0] nx, output bit bh);
        logic [NV-1:0] fresh_p, stale_p;
        fresh_p = '0; stale_p = '0;
        for (int i = 0; i < NV; i++) begin
            int nwhite; int last;
            nwhite = 0; last = 0;
            for (int j = 0; j < NV; j++)
                if (edge_on(i, j, en) && !c[j]) begin nwhite++; last = j; end
            if (c[i] && nwhite == 1) begin
                if (fr[i]) fresh_p[last] = 1'b1;
                else       stale_p[last] = 1'b1;
            end
        end
        nx = c | fresh_p | stale_p;
        bh = |(stale_p & ~fresh_p);
    endtask

    task automatic clear_graph();
        for (int i = 0; i < NV; i++) gadj[i] = '0;
    endtask

    task automatic add_edge(input int a, input int b);
        gadj[a][b] = 1'b1; gadj[b][a] = 1'b1;
    endtask

    task automatic load_graph();
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            adj_we = 1'b1; adj_idx = 4'(i); adj_row = gadj[i];
        end
        @(negedge clk);
        adj_we = 1'b0;
    endtask

    // Runs from a negedge; leaves at a negedge with done high.
    task automatic run_check(input logic [NV-1:0] init, input logic [NV-1:0] en,
                             input bit intrude,
                             output logic [NV-1:0] fin, output int steps);
        logic [NV-1:0] cur, fr, nx;
        bit bk, bh;
        int cnt;
        init_color = init; vtx_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cur = init & en; fr = cur; cnt = 1; bk = 0;
        chk(color == cur, "R11 start colouring", color, cur);
        chk(round_cnt == 1, "R4 initial step", round_cnt, 1);
        chk(running && !done, "R11 running after start", {running, done}, 2'b10);
        for (int r = 0; r < NV + 2; r++) begin
            model_round(cur, fr, en, nx, bh);
            if (intrude && r == 0) begin
                adj_we = 1'b1; adj_idx = 4'd0; adj_row = '0;
            end
            @(negedge clk);
            adj_we = 1'b0;
            if (nx == cur) break;
            chk((color & cur) == cur, "R2 no black lost", color, cur);
            fr = nx & ~cur; cur = nx; cnt++; bk = bk | bh;
            chk(color == cur, "R1 round colouring", color, cur);
            chk(round_cnt == CNT_W'(cnt), "R4 step count", round_cnt, cnt);
            chk(!done, "R3 not done while changing", done, 0);
        end
        chk(done && !running, "R3 done after no-change round", {running, done}, 2'b01);
        chk(color == cur, "R1 final colouring", color, cur);
        chk(round_cnt == CNT_W'(cnt), "R4 final step count", round_cnt, cnt);
        chk((color & ~en) == '0, "R9 disabled vertices white", color & ~en, 0);
        chk(all_black == ((cur & en) == en), "R9 all black flag", all_black, (cur & en) == en);
        chk(back_force == bk, "R7 back forcing flag", back_force, bk);
        @(negedge clk);
        chk(done && color == cur, "R3 colouring held after done", color, cur);
        fin = cur; steps = cnt;
    endtask

    initial begin
        logic [NV-1:0] fin, fin2;
        int steps, steps2;
        repeat (3) @(negedge clk);
        chk(color == '0 && !running && !done && round_cnt == 0, "R3 reset state",
            {color, running, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // AND gadget, full input sweep, with diagonal bits set.
        clear_graph();
        add_edge(0, 1); add_edge(0, 2); add_edge(1, 2);
        gadj[0][0] = 1'b1; gadj[2][2] = 1'b1;
        load_graph();
        chk(!sym_err, "R8 diagonal not a symmetry error", sym_err, 0);
        for (int v = 0; v < 4; v++) begin
            run_check(NV'(v), NV'(7), 0, fin, steps);
            chk(fin[2] == (v == 3), "R5 AND output", fin[2], v == 3);
            if (v == 3) chk(steps == 2, "R5 AND output at step 2", steps, 2);
        end

        // OR gadget, full input sweep.
        clear_graph();
        add_edge(0, 2); add_edge(0, 3); add_edge(1, 2); add_edge(1, 3);
        load_graph();
        for (int v = 0; v < 4; v++) begin
            run_check(NV'(v) | NV'(4), NV'(15), 0, fin, steps);
            chk(fin[3] == (v != 0), "R6 OR output", fin[3], v != 0);
            if (v != 0) begin
                chk(fin == NV'(15), "R6 all four black", fin, 15);
                chk(steps == 2, "R6 output at step 2", steps, 2);
            end
        end

        // Writes during a run are ignored; second run matches the first.
        run_check(NV'(5), NV'(15), 1, fin, steps);
        run_check(NV'(5), NV'(15), 0, fin2, steps2);
        chk(fin2 == NV'(15) && steps2 == steps, "R10 write during run ignored", fin2, 15);

        // Backward forcing: edges 0-1,1-2,0-3 with {0,2} black.
        clear_graph();
        add_edge(0, 1); add_edge(1, 2); add_edge(0, 3);
        load_graph();
        run_check(NV'(5), NV'(15), 0, fin, steps);
        chk(back_force && fin == NV'(15), "R7 backward forcing seen", back_force, 1);

        // Long path across all vertices.
        clear_graph();
        for (int i = 0; i < NV - 1; i++) add_edge(i, i + 1);
        load_graph();
        run_check(NV'(1), '1, 0, fin, steps);
        chk(steps == NV && all_black, "R4 path takes one round per vertex", steps, NV);

        // Restart in the middle of a run.
        init_color = NV'(1); vtx_en = '1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        run_check(NV'(1) << (NV - 1), NV'(16'h00FF) << 8, 0, fin, steps);
        chk(fin == (NV'(16'h00FF) << 8), "R11 restart with new mask", fin, 16'hFF00);

        // Symmetry error.
        @(negedge clk);
        adj_we = 1'b1; adj_idx = 4'd3; adj_row = NV'(16'h0100);
        @(negedge clk);
        adj_we = 1'b0;
        chk(sym_err, "R8 asymmetric edge flagged", sym_err, 1);

        // Random symmetric graphs against the model.
        for (int g = 0; g < 40; g++) begin
            logic [NV-1:0] en, ini;
            clear_graph();
            for (int i = 0; i < NV; i++)
                for (int j = i + 1; j < NV; j++)
                    if (($urandom % 5) == 0) add_edge(i, j);
            load_graph();
            chk(!sym_err, "R8 symmetric graph accepted", sym_err, 0);
            en = NV'($urandom) | NV'(16'h0F0F);
            ini = NV'($urandom) & NV'($urandom);
            run_check(ini, en, 0, fin, steps);
        end

        summary();
    end
endmodule